// File: doc/BRIEF.md
# Dual-Enable Static RAM Emulator

A clocked, synthesizable stand-in for an asynchronous byte-wide static RAM. The block offers the behaviour of such a part to logic that expects one: a word address, two chip selects of opposite polarity, a write strobe and an output strobe, all active as levels. Internally the storage is a plain register array sampled on a clock. The shared data bus of the real part is split into an input word, an output word and an output-enable flag, so an I/O pad or a board-level model can rebuild the three-state pin from them.

The block is selected only while the low-true select is low and the high-true select is high. While selected, the write strobe and output strobe choose between writing, driving read data, or an internal read that leaves the bus released. A read only reaches the bus after a programmable number of clock edges during which address and selection have held steady. Any address change, a fresh selection or a write starts the wait again, and the bus stays released until the new word is ready. The word count is `2**ADDR_W`. The 8192-word configuration uses `ADDR_W = 13`. The default of 11 keeps elaboration small.

Top module: `dual_enable_sram`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `data_oe` is 0.
- R2: When `cs_lo_n` is 1 or `cs_hi` is 0 (standby), `data_oe` is 0 whatever `we_n` and `oe_n` are.
- R3: When selected with `we_n` = 1 and `oe_n` = 1 (internal read), `data_oe` is 0. Lowering `oe_n` alone once the word is ready drives it in the same cycle, with no further wait.
- R4: When selected with `we_n` = 1 and `oe_n` = 0, `data_oe` becomes 1 and `data_out` equals the stored word after `ACCESS_CLKS` rising edges with steady address and selection. Before that, `data_oe` is 0.
- R5: When selected with `we_n` = 0, `data_oe` is 0 regardless of `oe_n`, and `data_in` is stored at `addr` on each rising edge.
- R6: While selected, a change of `addr` clears `data_oe` in the same cycle. It stays 0 until `ACCESS_CLKS` edges have passed at the new address.
- R7: A write ends as soon as `we_n` rises, `cs_lo_n` rises or `cs_hi` falls. An edge with `we_n` = 0 but the part deselected stores nothing.
- R8: While a read stays enabled at a steady address, `data_out` holds the same word from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset of the control state |
| addr | input | ADDR_W | Word address |
| cs_lo_n | input | 1 | Low-true chip select |
| cs_hi | input | 1 | High-true chip select |
| we_n | input | 1 | Low-true write strobe |
| oe_n | input | 1 | Low-true output strobe |
| data_in | input | DATA_W | Write data from the bus |
| data_out | output | DATA_W | Read data, zero while not driving |
| data_oe | output | 1 | 1 when the bus is driven by the block |

## Verification
Random writes followed by random reads at fresh addresses separate a correct store-and-fetch path from one that returns stale or neighbouring words, and they also check the latency count on every read. Back-to-back reads at differing addresses show whether the bus is released at once on an address step. Directed sequences cover the rest. Write attempts with each select inactive show whether a write is wrongly ended or wrongly accepted. Raising and lowering the output strobe over a ready word separates the internal-read case from a true read. Holding a read for several cycles confirms the output word stays stable.

// File: rtl/dual_enable_sram.sv
module dual_enable_sram #(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int ACCESS_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs_lo_n,
  input  logic              cs_hi,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(ACCESS_CLKS + 1);
  localparam logic [CNT_W-1:0] READY = CNT_W'(ACCESS_CLKS);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata;
  logic [ADDR_W-1:0] addr_q;
  logic              sel_q;
  logic [CNT_W-1:0]  cnt;
  logic              selected;

  assign selected = !cs_lo_n && cs_hi;

  always_ff @(posedge clk) begin
    if (selected && !we_n) mem[addr] <= data_in;
    rdata <= mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      sel_q  <= 1'b0;
      cnt    <= '0;
    end else begin
      addr_q <= addr;
      sel_q  <= selected;
      if (!selected || !we_n)          cnt <= '0;
      else if (!sel_q || addr != addr_q) cnt <= CNT_W'(1);
      else if (cnt != READY)            cnt <= cnt + CNT_W'(1);
    end
  end

  assign data_oe  = selected && we_n && !oe_n && sel_q && (addr == addr_q) && (cnt == READY);
  assign data_out = data_oe ? rdata : '0;

  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |-> !data_oe);
  assert_standby_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_lo_n || !cs_hi) |-> !data_oe);
  assert_internal_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !data_oe);
  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> $past(selected && we_n));
  assert_write_no_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !data_oe);
  assert_addr_step_hiz_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != $past(addr)) |-> !data_oe);
  assert_stable_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && $past(data_oe) && $stable(addr)) |-> $stable(data_out));
endmodule

// File: tb/dual_enable_sram_test.sv
module dual_enable_sram_test;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int ACC = 2;
  localparam int N = 1 << AW;

  logic clk = 0;
  logic rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic cs_lo_n = 1, cs_hi = 0, we_n = 1, oe_n = 1;
  logic [DW-1:0] data_in = '0;
  logic [DW-1:0] data_out;
  logic data_oe;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] shadow [N];
  bit written [N];
  bit last_read = 0;
  logic [AW-1:0] last_addr = '0;

  dual_enable_sram #(.ADDR_W(AW), .DATA_W(DW), .ACCESS_CLKS(ACC)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cs_lo_n(cs_lo_n), .cs_hi(cs_hi),
    .we_n(we_n), .oe_n(oe_n), .data_in(data_in), .data_out(data_out), .data_oe(data_oe));

  always #4 clk = ~clk;

  task automatic check(string req, logic [DW:0] act, logic [DW:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW:0] bus(bit oe, logic [DW-1:0] d);
    return {oe, oe ? d : {DW{1'b0}}};
  endfunction

  task automatic step(); @(posedge clk); #1; endtask
  task automatic look(); @(negedge clk); endtask

  task automatic write_word(logic [AW-1:0] a, logic [DW-1:0] d);
    step();
    cs_lo_n = 0; cs_hi = 1; we_n = 0; oe_n = 1'($urandom); addr = a; data_in = d;
    look(); check("R5 no drive while writing", {data_oe, data_out}, bus(0, 0));
    step(); we_n = 1; oe_n = 1;
    shadow[a] = d; written[a] = 1; last_read = 0;
  endtask

  task automatic read_word(logic [AW-1:0] a);
    bit fresh;
    fresh = !(last_read && a == last_addr);
    step();
    cs_lo_n = 0; cs_hi = 1; we_n = 1; oe_n = 0; addr = a;
    look();
    if (fresh) check(last_read ? "R6 release on address step" : "R4 not ready yet",
                     {data_oe, data_out}, bus(0, 0));
    for (int k = 1; k <= ACC; k++) begin
      step(); look();
      if (fresh && k < ACC) check("R6 still waiting", {data_oe, data_out}, bus(0, 0));
      else check("R4 read word", {data_oe, data_out}, bus(1, shadow[a]));
    end
    last_read = 1; last_addr = a;
  endtask

  task automatic deselect();
    step(); cs_lo_n = 1; cs_hi = 0; we_n = 1; oe_n = 1; last_read = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    cs_lo_n = 0; cs_hi = 1; oe_n = 0;
    repeat (3) begin look(); check("R1 reset quiet", {data_oe, data_out}, bus(0, 0)); end
    step(); rst_n = 1;
    look(); check("R1 first cycle after reset", {data_oe, data_out}, bus(0, 0));
    deselect();

    write_word(11'h005, 8'h3C);
    write_word(11'h7FF, 8'hA5);
    write_word(11'h000, 8'h5A);
    read_word(11'h005);
    read_word(11'h7FF);
    read_word(11'h000);

    step(); we_n = 0; oe_n = 0; cs_lo_n = 1; cs_hi = 1; addr = 11'h005; data_in = 8'hEE;
    look(); check("R2 standby via low-true select", {data_oe, data_out}, bus(0, 0));
    step(); cs_lo_n = 0; cs_hi = 0; data_in = 8'hDD;
    look(); check("R2 standby via high-true select", {data_oe, data_out}, bus(0, 0));
    step(); we_n = 1; last_read = 0;
    read_word(11'h005);
    check("R7 deselected write stored nothing", {1'b1, data_out}, {1'b1, 8'h3C});

    write_word(11'h010, 8'h77);
    step(); cs_lo_n = 0; cs_hi = 1; we_n = 1; oe_n = 1; addr = 11'h010;
    for (int k = 0; k < 4; k++) begin
      look(); check("R3 internal read keeps bus released", {data_oe, data_out}, bus(0, 0));
      step();
    end
    oe_n = 0;
    look(); check("R3 output strobe drives ready word", {data_oe, data_out}, bus(1, 8'h77));
    for (int k = 0; k < 3; k++) begin
      step(); look(); check("R8 held read stays stable", {data_oe, data_out}, bus(1, 8'h77));
    end
    last_read = 1; last_addr = 11'h010;
    read_word(11'h7FF);

    for (int i = 0; i < 60; i++) write_word(AW'($urandom % N), DW'($urandom));
    for (int i = 0; i < 150; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom % N);
      if (written[a]) read_word(a);
    end
    deselect();
    look(); check("R2 standby after traffic", {data_oe, data_out}, bus(0, 0));

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule